// File: doc/BRIEF.md
# Shared-Table Paged Address Translator

This block turns a 16-bit virtual byte address into a 22-bit physical address for a processor with three privilege modes (kernel, supervisor, user). Each mode has an instruction space and a data space, which gives six address spaces. Instruction space serves instruction fetches, index words, absolute addresses and immediate operands. Data space serves every other reference. The caller picks the space through the `mode` and `is_data` inputs.

There are four full page tables of 64 entries each, and the six spaces share them. Each space holds a setting that names the table it uses, an upper limit on its virtual page number, and a bypass bit. When bypass is set, the space is unmapped. A page entry holds a 12-bit physical page number, a 2-bit access code and two usage bits: accessed and written. A legal mapped reference sets the usage bits on the clock edge. Translation and fault detection are combinational. A single write port loads both the page entries and the space settings.

Top module: `paged_xlate`

## Requirements
- R1: After reset, every space has bypass set, selects table 0 and has limit 63. Every page entry has access code 00, physical page 0, and both usage bits clear.
- R2: The space number is `2*mode + is_data`. Kernel is mode 0, supervisor is mode 1 and user is mode 2. Mode 3 behaves exactly as user.
- R3: In a bypass space, `paddr` is the virtual address zero-extended to 22 bits. A request there never faults, and the usage bits never change. `stat_acc` and `stat_wr` read 0 while the space is in bypass.
- R4: In a mapped space, the virtual page is `vaddr[15:10]`. `paddr` is `{ppn, vaddr[9:0]}`, where `ppn` comes from the entry for that page in the table the space selects.
- R5: Two spaces that select the same table see the same entries and the same usage bits. Spaces that select different tables are independent of each other.
- R6: A mapped request whose virtual page is greater than the space's limit faults with code 01. This check takes priority over the access-code check.
- R7: The access code is 00 for no access, 01 for read only, 10 for write only and 11 for read-write. A read needs bit 0 set and a write needs bit 1 set. A violation faults with code 10, and fault code 11 never appears.
- R8: A write port loads settings when `cfg_we` is 1. With `cfg_space` at 0, `cfg_idx[7:6]` selects the table and `cfg_idx[5:0]` selects the page, and the entry takes `cfg_data[11:0]` as ppn and `cfg_data[13:12]` as access code. With `cfg_space` at 1, `cfg_idx[2:0]` selects the space, and the space takes `cfg_data[0]` as bypass, `cfg_data[2:1]` as table and `cfg_data[8:3]` as limit. Space numbers 6 and 7 are ignored.
- R9: A legal mapped request sets the page's accessed bit at the clock edge. `stat_acc` shows the stored bit for the page being addressed.
- R10: A legal mapped write also sets the written bit, shown on `stat_wr`. A faulting request changes no usage bit.
- R11: Writing a page entry clears both of its usage bits.
- R12: `ok` is 1 only for a request (`req` = 1) with fault code 00. With `req` at 0, `ok` is 0, `fault` is 00 and no usage bit changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode | input | 2 | Privilege mode: 0 kernel, 1 supervisor, 2 or 3 user |
| is_data | input | 1 | 1 selects the data space, 0 the instruction space |
| req | input | 1 | A reference is presented this cycle |
| wr | input | 1 | 1 for a write reference, 0 for a read |
| vaddr | input | 16 | Virtual byte address |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_space | input | 1 | 1 writes a space setting, 0 writes a page entry |
| cfg_idx | input | 8 | Entry index: {table, page} or space number |
| cfg_data | input | 14 | Configuration data |
| paddr | output | 22 | Physical byte address |
| ok | output | 1 | Request is legal and proceeds |
| fault | output | 2 | 00 none, 01 over limit, 10 access violation |
| stat_acc | output | 1 | Accessed bit of the addressed page |
| stat_wr | output | 1 | Written bit of the addressed page |

## Verification
On every cycle, the assertions check four properties:
- a legal mapped reference shows its accessed bit on the following cycle;
- a page's written bit never appears without its accessed bit;
- the page-limit fault wins over the access-code fault;
- the reserved fault code never appears.

The address arithmetic needs the bench's sweeps, and so do the following behaviours:
- sharing of a table between spaces;
- the handling of mode 3;
- the clearing of usage bits when an entry is rewritten;
- the absence of any effect from bypassed, faulting or idle references.

// File: rtl/paged_xlate.sv
module paged_xlate #(
  parameter int VA_W  = 16,
  parameter int OFF_W = 10,
  parameter int PPN_W = 12,
  parameter int NTBL  = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [1:0]               mode,
  input  logic                     is_data,
  input  logic                     req,
  input  logic                     wr,
  input  logic [VA_W-1:0]          vaddr,
  input  logic                     cfg_we,
  input  logic                     cfg_space,
  input  logic [$clog2(NTBL)+VA_W-OFF_W-1:0] cfg_idx,
  input  logic [PPN_W+1:0]         cfg_data,
  output logic [PPN_W+OFF_W-1:0]   paddr,
  output logic                     ok,
  output logic [1:0]               fault,
  output logic                     stat_acc,
  output logic                     stat_wr
);
  localparam int VPN_W  = VA_W - OFF_W;
  localparam int NPAGE  = 1 << VPN_W;
  localparam int TBL_W  = $clog2(NTBL);
  localparam int NENT   = NTBL * NPAGE;
  localparam int IDX_W  = TBL_W + VPN_W;
  localparam int NSPACE = 6;
  localparam int PA_W   = PPN_W + OFF_W;

  logic [PPN_W-1:0] ppn_q [NENT];
  logic [1:0]       acc_q [NENT];
  logic [NENT-1:0]  sa_q, sw_q;
  logic [TBL_W-1:0] tsel_q [NSPACE];
  logic [VPN_W-1:0] lim_q  [NSPACE];
  logic [NSPACE-1:0] byp_q;

  logic [2:0]       sp;
  logic [VPN_W-1:0] vpn;
  logic [IDX_W-1:0] eidx;
  logic             byp, over, viol, upd;
  logic [1:0]       acc;

  assign sp   = {(mode == 2'b11) ? 2'b10 : mode, is_data};
  assign vpn  = vaddr[VA_W-1:OFF_W];
  assign byp  = byp_q[sp];
  assign eidx = {tsel_q[sp], vpn};
  assign acc  = acc_q[eidx];
  assign over = vpn > lim_q[sp];
  assign viol = wr ? !acc[1] : !acc[0];

  always_comb begin
    fault = 2'b00;
    if (req && !byp) begin
      if (over)      fault = 2'b01;
      else if (viol) fault = 2'b10;
    end
  end

  assign ok       = req && (fault == 2'b00);
  assign upd      = ok && !byp;
  assign paddr    = byp ? PA_W'(vaddr) : {ppn_q[eidx], vaddr[OFF_W-1:0]};
  assign stat_acc = !byp && sa_q[eidx];
  assign stat_wr  = !byp && sw_q[eidx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NENT; i++) begin
        ppn_q[i] <= '0;
        acc_q[i] <= 2'b00;
      end
      sa_q <= '0;
      sw_q <= '0;
      for (int s = 0; s < NSPACE; s++) begin
        tsel_q[s] <= '0;
        lim_q[s]  <= '1;
      end
      byp_q <= '1;
    end else begin
      if (upd) begin
        sa_q[eidx] <= 1'b1;
        if (wr) sw_q[eidx] <= 1'b1;
      end
      if (cfg_we && !cfg_space) begin
        ppn_q[cfg_idx] <= cfg_data[PPN_W-1:0];
        acc_q[cfg_idx] <= cfg_data[PPN_W+1:PPN_W];
        sa_q[cfg_idx]  <= 1'b0;
        sw_q[cfg_idx]  <= 1'b0;
      end
      if (cfg_we && cfg_space && (cfg_idx[2:0] < 3'(NSPACE))) begin
        byp_q[cfg_idx[2:0]]  <= cfg_data[0];
        tsel_q[cfg_idx[2:0]] <= cfg_data[TBL_W:1];
        lim_q[cfg_idx[2:0]]  <= cfg_data[TBL_W+VPN_W:TBL_W+1];
      end
    end
  end

  // R9
  stat_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !cfg_we) |=> (!($stable(vaddr) && $stable(mode) && $stable(is_data)) || stat_acc));

  // R10
  wr_imp_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_wr |-> stat_acc);

  // R6
  lim_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !byp && (vpn > lim_q[sp])) |-> (fault == 2'b01 && !ok));

  // R7
  no_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault != 2'b11);
endmodule

// File: tb/sim_paged_xlate.sv
module sim_paged_xlate;
  logic        clk = 0, rst_n = 0;
  logic [1:0]  mode = 0;
  logic        is_data = 0, req = 0, wr = 0;
  logic [15:0] vaddr = 0;
  logic        cfg_we = 0, cfg_space = 0;
  logic [7:0]  cfg_idx = 0;
  logic [13:0] cfg_data = 0;
  logic [21:0] paddr;
  logic        ok, stat_acc, stat_wr;
  logic [1:0]  fault;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  logic [11:0] m_ppn [256];
  logic [1:0]  m_acc [256];
  bit          m_sa  [256];
  bit          m_sw  [256];
  bit          m_byp [6];
  int          m_tbl [6];
  int          m_lim [6];

  paged_xlate u0 (.clk, .rst_n, .mode, .is_data, .req, .wr, .vaddr,
    .cfg_we, .cfg_space, .cfg_idx, .cfg_data, .paddr, .ok, .fault, .stat_acc, .stat_wr);

  always #10 clk = ~clk;

  task automatic chk(string tag, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic put_page(int t, int p, logic [11:0] pn, logic [1:0] ac);
    @(negedge clk);
    cfg_we = 1; cfg_space = 0; cfg_idx = 8'(t*64 + p); cfg_data = {ac, pn};
    @(posedge clk);
    m_ppn[t*64+p] = pn; m_acc[t*64+p] = ac; m_sa[t*64+p] = 0; m_sw[t*64+p] = 0;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic put_space(int s, bit b, int t, int lim);
    @(negedge clk);
    cfg_we = 1; cfg_space = 1; cfg_idx = 8'(s);
    cfg_data = 14'({6'(lim), 2'(t), b});
    @(posedge clk);
    if (s < 6) begin m_byp[s] = b; m_tbl[s] = t; m_lim[s] = lim; end
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic access(string tag, int md, bit d, bit w, logic [15:0] va, bit rq = 1);
    int s, e, pg;
    logic [1:0] ef;
    logic [21:0] ep;
    @(negedge clk);
    mode = 2'(md); is_data = d; wr = w; vaddr = va; req = rq;
    #1;
    s  = ((md == 3) ? 2 : md) * 2 + d;
    pg = va[15:10];
    e  = m_tbl[s] * 64 + pg;
    if (m_byp[s]) begin
      ef = 0; ep = {6'b0, va};
    end else begin
      ep = {m_ppn[e], va[9:0]};
      if (pg > m_lim[s]) ef = 1;
      else if (w ? !m_acc[e][1] : !m_acc[e][0]) ef = 2;
      else ef = 0;
    end
    if (!rq) ef = 0;
    chk({tag, " fault"}, fault, ef);
    chk({tag, " ok R12"}, ok, rq && ef == 0);
    if (rq && ef == 0) chk({tag, " paddr"}, paddr, ep);
    chk({tag, " stat_acc"}, stat_acc, m_byp[s] ? 0 : m_sa[e]);
    chk({tag, " stat_wr"}, stat_wr, m_byp[s] ? 0 : m_sw[e]);
    @(posedge clk);
    if (rq && ef == 0 && !m_byp[s]) begin
      m_sa[e] = 1;
      if (w) m_sw[e] = 1;
    end
    @(negedge clk); req = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) begin m_ppn[i] = 0; m_acc[i] = 0; m_sa[i] = 0; m_sw[i] = 0; end
    for (int s = 0; s < 6; s++) begin m_byp[s] = 1; m_tbl[s] = 0; m_lim[s] = 63; end
    repeat (3) @(posedge clk);
    rst_n = 1;

    // R1 R3: reset state is bypass everywhere
    access("R1 reset bypass user", 2, 1, 1, 16'hBEEF);
    access("R3 bypass kernel", 0, 0, 0, 16'h1234);
    // R1: reset entries are no-access, usage bits clear
    put_space(0, 0, 0, 63);
    access("R1 reset entry", 0, 0, 0, 16'h0400);
    access("R1 reset entry w", 0, 0, 1, 16'hFC00);

    // R8: load all tables
    for (int t = 0; t < 4; t++)
      for (int p = 0; p < 64; p++)
        put_page(t, p, 12'(((t*64 + p) * 37 + 5)), 2'((t + p) % 4));
    // R2 R5: space s uses table s%4, decreasing limits
    for (int s = 0; s < 6; s++) put_space(s, 0, s % 4, 63 - s * 9);
    put_space(6, 1, 3, 0);
    put_space(7, 1, 3, 0);

    // R4 R6 R7 R9 R10: sweep every space and page, read then write
    for (int s = 0; s < 6; s++)
      for (int p = 0; p < 64; p++) begin
        access("R4 R6 R7 R9 rd", s / 2, s[0], 0, 16'({6'(p), 10'((p * 7 + s) & 10'h3FF)}));
        access("R10 R7 wr", s / 2, s[0], 1, 16'({6'(p), 10'((p * 13 + s * 3) & 10'h3FF)}));
      end

    // R5: spaces 4 and 0 share table 0
    access("R5 shared user I", 2, 0, 0, 16'h0C00);
    access("R5 shared kernel I", 0, 0, 0, 16'h0C00);

    // R2: mode 3 behaves as user
    for (int p = 0; p < 64; p += 5) begin
      access("R2 mode3 D", 3, 1, 1, 16'({6'(p), 10'h155}));
      access("R2 mode3 I", 3, 0, 0, 16'({6'(p), 10'h2AA}));
    end

    // R12: idle cycles change nothing
    put_page(2, 7, 12'hABC, 2'b11);
    access("R12 idle", 1, 0, 1, 16'h1C00, 0);
    access("R12 after idle", 1, 0, 0, 16'h1C00);
    access("R9 seen", 1, 0, 0, 16'h1C00);

    // R11: rewrite clears usage bits
    put_page(2, 7, 12'h123, 2'b11);
    access("R11 cleared", 1, 0, 1, 16'h1C08);
    access("R10 wr seen", 1, 0, 0, 16'h1C08);

    // R3: bypass leaves usage bits alone
    put_page(1, 3, 12'h777, 2'b11);
    put_space(1, 1, 1, 63);
    access("R3 bypass D", 0, 1, 1, 16'h0C10);
    put_space(1, 0, 1, 63);
    access("R3 after bypass", 0, 1, 0, 16'h0C10);

    // R6: limit beats access code; R7: violation leaves bits
    put_page(3, 40, 12'h0F0, 2'b00);
    put_space(3, 0, 3, 39);
    access("R6 prio", 1, 1, 0, 16'hA000);
    put_space(3, 0, 3, 40);
    access("R7 noacc", 1, 1, 0, 16'hA000);
    put_page(3, 40, 12'h0F0, 2'b10);
    access("R7 wo read", 1, 1, 0, 16'hA004);
    access("R7 wo write", 1, 1, 1, 16'hA004);
    access("R10 wo stat", 1, 1, 0, 16'hA3FF);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule